// File: doc/BRIEF.md
# Configurable aspect-ratio dual-port RAM

This block is a simple dual-port memory of 1,152 bits. One port only writes and the other only reads, and each port runs on its own clock. A 2-bit organisation input selects how the fixed store is shaped: 512 words of 2 bits, 256 of 4, 128 of 9 or 64 of 18. The port buses are always sized for the widest and deepest case: a 9-bit address and 18-bit data. Each mode uses only the low parts of these buses.

All four shapes are views of one physical bit array. A word at address A in a W-bit mode occupies store bits A*W up to A*W+W-1. Data written in one mode can therefore be read back in another mode, with a predictable bit layout. The read port has two modes. It can return the addressed word through an output register loaded on the read clock, or it can present the word combinationally from the address.

Top module: `cfg_dpram`

## Requirements
- R1: The `org` input selects the shape: 2'b00 is 512x2, 2'b01 is 256x4, 2'b10 is 128x9 and 2'b11 is 64x18. A word at effective address A in a W-bit mode occupies store bits A*W through A*W+W-1, so data written in one mode reads back in another according to that bit layout.
- R2: In each mode only the low log2(depth) address bits are used (9, 8, 7 or 6 bits). Higher address bits on either port are ignored.
- R3: A write stores only the low W bits of `wr_data`. The higher data bits leave the store unchanged.
- R4: Read-data bits at position W and above are always zero, in both read modes.
- R5: A write takes effect on the rising edge of `wr_clk`, and only when `wr_en` is high at that edge. With `wr_en` low, the store is unchanged.
- R6: With `rd_async` low, the output register loads the addressed word on a rising `rd_clk` edge when `rd_en` is high. It holds its value when `rd_en` is low.
- R7: With `rd_async` high, `rd_data` follows `rd_addr`, `org` and the store combinationally. A completed write is therefore visible without any read-clock edge.
- R8: When `wr_clk` and `rd_clk` are the same clock, a registered read of an address at the same edge that writes it returns the old word. The following read edge returns the new word.
- R9: While `rst_n` is low, the output register is zero. It clears as soon as `rst_n` falls. Reset is released on the read clock through a two-stage synchroniser.
- R10: The two ports operate correctly with unrelated clocks. Back-to-back writes and reads may run at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on rd_clk |
| org | input | 2 | Organisation select (see R1) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data, low W bits used |
| rd_en | input | 1 | Read enable for the registered read |
| rd_addr | input | 9 | Read word address |
| rd_async | input | 1 | 1 selects combinational read, 0 selects registered read |
| rd_data | output | 18 | Read data, zero above bit W-1 |

## Verification
A wrong bit in the store is invisible until it is read. With `rd_async` high it shows at the port at once. In registered mode it shows one read-clock edge after an enabled read. A decode error in the write mapping is different: it corrupts neighbouring words or the words of other shapes. For that reason every shape is read back after writes made in a different shape, which exposes any misplaced bit offset within one pass over the address range. A stale or wrongly enabled output register shows at the first read-clock edge where its expected hold or load diverges from what was requested.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;

  typedef enum logic [1:0] {
    ORG_512X2 = 2'b00,
    ORG_256X4 = 2'b01,
    ORG_128X9 = 2'b10,
    ORG_64X18 = 2'b11
  } org_e;

  localparam int unsigned WID_W = 5;

  function automatic logic [WID_W-1:0] org_width(input org_e o);
    case (o)
      ORG_512X2: return 5'd2;
      ORG_256X4: return 5'd4;
      ORG_128X9: return 5'd9;
      default:   return 5'd18;
    endcase
  endfunction

  function automatic logic [8:0] org_amask(input org_e o);
    case (o)
      ORG_512X2: return 9'h1FF;
      ORG_256X4: return 9'h0FF;
      ORG_128X9: return 9'h07F;
      default:   return 9'h03F;
    endcase
  endfunction

endpackage

// File: rtl/cfg_dpram_map.sv
module cfg_dpram_map
  import cfg_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BITS   = 1152,
  parameter int unsigned IDX_W  = $clog2(BITS)
) (
  input  org_e              org_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  base_o,
  output logic [WID_W-1:0]  width_o
);

  logic [ADDR_W-1:0] addr_eff;

  always_comb begin
    width_o  = org_width(org_i);
    addr_eff = addr_i & ADDR_W'(org_amask(org_i));
    base_o   = IDX_W'(addr_eff) * IDX_W'(width_o);
  end

endmodule

// File: rtl/cfg_dpram_store.sv
module cfg_dpram_store
  import cfg_dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BITS   = 1152,
  parameter int unsigned IDX_W  = $clog2(BITS)
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [BITS-1:0]   bits_o
);

  localparam int unsigned SEL_W = $clog2(DATA_W);
  localparam int unsigned PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] wd_pad;
  logic [BITS-1:0]  hit_vec;
  logic [BITS-1:0]  bits_d;

  assign wd_pad = PAD_W'(wr_data_i);

  for (genvar g = 0; g < BITS; g++) begin : g_bit
    logic [IDX_W-1:0] off;
    assign off        = IDX_W'(g) - base_i;
    assign hit_vec[g] = wr_en && (off < IDX_W'(width_i));
    assign bits_d[g]  = hit_vec[g] ? wd_pad[off[SEL_W-1:0]] : bits_o[g];
  end

  always_ff @(posedge wr_clk) begin
    bits_o <= bits_d;
  end

  // R5: an idle write port leaves every stored bit untouched
  a_r5_no_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_o))
    else $error("a_r5_no_write");

  // R1: a write touches exactly as many bits as the selected word width
  a_r1_width_bits: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en |-> ($countones(hit_vec) == int'(width_i)))
    else $error("a_r1_width_bits");

  // R2: the masked address never reaches past the end of the store
  a_r2_in_range: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en |-> (int'(base_i) + int'(width_i) <= int'(BITS)))
    else $error("a_r2_in_range");

endmodule

// File: rtl/cfg_dpram_rdport.sv
module cfg_dpram_rdport
  import cfg_dpram_pkg::*;
#(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned BITS        = 1152,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = $clog2(BITS)
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_async,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [BITS-1:0]   bits_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [DATA_W-1:0]      word;
  logic [DATA_W-1:0]      rd_d;
  logic [DATA_W-1:0]      rd_q;

  // reset asserts at once, releases after SYNC_STAGES read-clock edges
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // pick W bits starting at the word base, zero above
  always_comb begin
    word = '0;
    for (int k = 0; k < DATA_W; k++) begin
      logic [IDX_W:0] idx;
      idx = {1'b0, base_i} + (IDX_W+1)'(k);
      if ((WID_W'(k) < width_i) && (idx < (IDX_W+1)'(BITS)))
        word[k] = bits_i[idx[IDX_W-1:0]];
    end
  end

  assign rd_d = rd_en ? word : rd_q;

  always_ff @(posedge rd_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign rd_data_o = rd_async ? word : rd_q;

  // R6: register holds while the read enable is low
  a_r6_hold: assert property (@(posedge rd_clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rd_q))
    else $error("a_r6_hold");

  // R4: a loaded word carries nothing above its width
  a_r4_unused_zero: assert property (@(posedge rd_clk) disable iff (!rst_sync_n)
    rd_en |=> ((rd_q >> $past(width_i)) == '0))
    else $error("a_r4_unused_zero");

endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
  import cfg_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BITS   = 1152
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [1:0]        org,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_async,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned IDX_W = $clog2(BITS);

  org_e             org_sel;
  logic [IDX_W-1:0] wr_base;
  logic [WID_W-1:0] wr_width;
  logic [IDX_W-1:0] rd_base;
  logic [WID_W-1:0] rd_width;
  logic [BITS-1:0]  store_bits;

  assign org_sel = org_e'(org);

  cfg_dpram_map #(.ADDR_W(ADDR_W), .BITS(BITS), .IDX_W(IDX_W)) u_wr_map (
    .org_i(org_sel), .addr_i(wr_addr), .base_o(wr_base), .width_o(wr_width)
  );

  cfg_dpram_map #(.ADDR_W(ADDR_W), .BITS(BITS), .IDX_W(IDX_W)) u_rd_map (
    .org_i(org_sel), .addr_i(rd_addr), .base_o(rd_base), .width_o(rd_width)
  );

  cfg_dpram_store #(.DATA_W(DATA_W), .BITS(BITS), .IDX_W(IDX_W)) u_store (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .base_i(wr_base),
    .width_i(wr_width), .wr_data_i(wr_data), .bits_o(store_bits)
  );

  cfg_dpram_rdport #(.DATA_W(DATA_W), .BITS(BITS), .SYNC_STAGES(2), .IDX_W(IDX_W)) u_rdport (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_async(rd_async),
    .base_i(rd_base), .width_i(rd_width), .bits_i(store_bits), .rd_data_o(rd_data)
  );

endmodule

// File: tb/cfg_dpram_tb.sv
`timescale 1ns/100ps
module cfg_dpram_tb;

  logic        wr_clk = 1'b0;
  logic        rd_free = 1'b0;
  logic        same = 1'b0;
  logic        rst_n;
  logic [1:0]  org;
  logic        wr_en, rd_en, rd_async;
  logic [8:0]  wr_addr, rd_addr;
  logic [17:0] wr_data;
  wire  [17:0] rd_data;
  wire         rd_clk = same ? wr_clk : rd_free;

  int    errors = 0;
  int    checks = 0;
  bit    chk_on = 1'b0;
  string tag = "R9";

  bit   [1151:0] ref_mem;
  logic [17:0]   exp_q = '0;

  cfg_dpram u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .org(org),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_async(rd_async), .rd_data(rd_data)
  );

  initial forever #4 wr_clk = ~wr_clk;          // 125 MHz
  initial begin #0.5; forever #5 rd_free = ~rd_free; end

  function automatic int wid(input logic [1:0] m);
    case (m) 2'd0: return 2; 2'd1: return 4; 2'd2: return 9; default: return 18; endcase
  endfunction
  function automatic int dep(input logic [1:0] m);
    return 1152 / wid(m) >= 512 ? 512 : (m == 2'd1 ? 256 : (m == 2'd2 ? 128 : 64));
  endfunction
  function automatic logic [17:0] ref_read(input logic [8:0] a, input logic [1:0] m);
    logic [17:0] r = '0;
    int b = (int'(a) % dep(m)) * wid(m);
    for (int k = 0; k < wid(m); k++) r[k] = ref_mem[b + k];
    return r;
  endfunction
  task automatic ref_write(input logic [8:0] a, input logic [17:0] d, input logic [1:0] m);
    int b = (int'(a) % dep(m)) * wid(m);
    for (int k = 0; k < wid(m); k++) ref_mem[b + k] = d[k];
  endtask
  task automatic model_rd();
    if (!rst_n) exp_q = '0;
    else if (rd_en) exp_q = ref_read(rd_addr, org);
  endtask

  always @(posedge wr_clk) begin
    if (same) model_rd();
    if (wr_en) ref_write(wr_addr, wr_data, org);
  end
  always @(posedge rd_free) if (!same) model_rd();
  always @(negedge rst_n) exp_q = '0;

  task automatic check(input string t, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge rd_clk) if (chk_on)
    check(tag, rd_data, rd_async ? ref_read(rd_addr, org) : exp_q);

  task automatic wr(input logic [8:0] a, input logic [17:0] d, input logic en);
    @(posedge wr_clk); #2;
    wr_en = en; wr_addr = a; wr_data = d;
  endtask
  task automatic rd(input logic [8:0] a, input logic en);
    @(posedge rd_clk); #2;
    rd_en = en; rd_addr = a;
  endtask
  function automatic logic [17:0] pat(input int a);
    return 18'((a * 7919 + 12345) ^ (a << 11));
  endfunction

  initial begin
    repeat (200000) @(posedge wr_clk);
    checks++; errors++;
    $display("FAIL watchdog R10: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; org = 2'd3; wr_en = 0; rd_en = 0; rd_async = 0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk); check("R9 reset value", rd_data, 18'h0);
    @(posedge wr_clk); #2 rst_n = 1'b1;
    repeat (6) @(posedge rd_free);
    chk_on = 1'b1;

    // R5: fill in 64x18, disabled writes in between carry garbage
    tag = "R5 fill";
    for (int a = 0; a < 64; a++) begin
      wr(9'(a), pat(a), 1'b1);
      wr(9'((a + 1) % 64), 18'h3FFFF, 1'b0);
    end
    wr(9'd0, '0, 1'b0);

    tag = "R6 sync read";
    for (int a = 0; a < 64; a++) rd(9'(a), 1'b1);
    tag = "R6 hold";
    rd(9'd40, 1'b0); rd(9'd41, 1'b0);
    repeat (3) @(posedge rd_free);

    tag = "R7 async read";
    @(posedge rd_clk); #2 rd_async = 1'b1;
    for (int a = 0; a < 64; a++) rd(9'(a), 1'b0);

    // R1 R2 R3 R4: each shape, addresses with upper bits set
    for (int m = 0; m < 4; m++) begin
      @(posedge wr_clk); #2 org = 2'(m);
      tag = $sformatf("R1 R2 R3 R4 mode %0d", m);
      for (int i = 0; i < 12; i++) begin
        logic [8:0] a;
        a = 9'((i * 37 + m * 5) % dep(2'(m)));
        wr(a | ~9'(dep(2'(m)) - 1), pat(i + 100 * m) | 18'h20000, 1'b1);
      end
      wr(9'd0, '0, 1'b0);
      @(posedge rd_clk); #2 rd_async = 1'b1;
      for (int i = 0; i < 12; i++) rd(9'((i * 37 + m * 5) % dep(2'(m))) | 9'h1C0, 1'b0);
      @(posedge rd_clk); #2 rd_async = 1'b0;
      for (int i = 0; i < 12; i++) rd(9'((i * 37 + m * 5) % dep(2'(m))), 1'b1);
      rd(9'd0, 1'b0);
    end

    // R1: written as 512x2, read back as 64x18 and 128x9
    tag = "R1 cross-shape";
    @(posedge wr_clk); #2 org = 2'd0;
    for (int a = 0; a < 40; a++) wr(9'(a * 13), pat(a + 500), 1'b1);
    wr(9'd0, '0, 1'b0);
    @(posedge wr_clk); #2 org = 2'd3;
    @(posedge rd_clk); #2 rd_async = 1'b1;
    for (int a = 0; a < 64; a++) rd(9'(a), 1'b0);
    @(posedge wr_clk); #2 org = 2'd2;
    for (int a = 0; a < 128; a++) rd(9'(a), 1'b0);

    // R10: concurrent traffic on unrelated clocks
    tag = "R10 unrelated clocks";
    for (int pass = 0; pass < 2; pass++) begin
      @(posedge rd_clk); #2 rd_async = pass[0];
      fork
        for (int i = 0; i < 60; i++) wr(9'(i * 3), pat(i + 900 + pass), 1'b1);
        for (int i = 0; i < 60; i++) rd(9'(i * 3), 1'b1);
      join
      wr(9'd0, '0, 1'b0);
      rd(9'd0, 1'b0);
    end

    // R7: async read shows a write without a read edge
    @(posedge wr_clk); #2 org = 2'd3;
    tag = "R7 write-through";
    @(posedge rd_clk); #2 rd_async = 1'b1;
    rd(9'd9, 1'b0);
    wr(9'd9, 18'h0F0F0, 1'b1);
    wr(9'd9, 18'h0, 1'b0);
    #1 check("R7 async sees new word", rd_data, 18'h0F0F0);

    // R9: reset clears the loaded register at once
    @(posedge rd_clk); #2 rd_async = 1'b0;
    rd(9'd9, 1'b1); rd(9'd9, 1'b0);
    @(posedge rd_free); #2;
    check("R9 loaded before reset", rd_data, 18'h0F0F0);
    chk_on = 1'b0;
    rst_n = 1'b0;
    #1 check("R9 async clear", rd_data, 18'h0);
    @(posedge wr_clk); #2 rst_n = 1'b1;
    repeat (6) @(posedge rd_free);
    chk_on = 1'b1;

    // R8: shared clock, same address, same edge
    @(negedge wr_clk); #1 same = 1'b1;
    tag = "R8 shared clock";
    wr(9'd7, 18'h11111, 1'b1);
    fork
      wr(9'd7, 18'h2AAAA, 1'b1);
      rd(9'd7, 1'b1);
    join
    wr(9'd7, 18'h0, 1'b0);
    @(negedge wr_clk); check("R8 old word at shared edge", rd_data, 18'h11111);
    @(negedge wr_clk); check("R8 new word next edge", rd_data, 18'h2AAAA);
    rd(9'd0, 1'b0);
    @(negedge wr_clk); #1 same = 1'b0;
    repeat (4) @(posedge rd_free);

    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule